// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs clause-22 management transactions between a host and an Ethernet PHY over the two-wire MDC/MDIO bus. The host loads one 32-bit frame word in a single write, then waits for a sticky completion flag. The word holds the start code, opcode, PHY address, register address, turnaround pattern and a 16-bit data field, most significant bit first. The engine sends a preamble of 32 ones and then the 32 frame bits. For a read, it releases MDIO for the second turnaround bit and the data phase. It shifts the PHY's 16 bits into the low half of the frame word, and the host reads the result from there.

A separate speed value sets the MDC rate. MDC is high for `speed` system clocks and low for `speed` system clocks. MDC runs only while a transaction is in progress. A speed of zero holds the clock where it is, which pauses a transaction already in flight. The completion flag stays set until the host writes a 1 to clear it.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `evt` is 0, the frame word is all zeros and the speed value is 0.
- R2: During a transaction, MDC stays low for `speed` clocks and then high for `speed` clocks, one full period per slot. MDC is held low while no transaction is in progress.
- R3: The transaction has 64 slots. Slots 0 to 31 drive 1. Slot 32+k drives frame bit 31-k. MDIO changes only when MDC falls, or on the first clock of a transaction.
- R4: When frame bits 29:28 are not `10`, MDIO stays driven through all 64 slots and the frame word is left unchanged.
- R5: When frame bits 29:28 are `10` (read), `mdio_oe` is low from slot 47 (second turnaround bit) to the end. `mdio_i` is sampled on each MDC rise in slots 48 to 63 and shifted in MSB first, so the data ends up in frame bits 15:0. Bits 31:16 are not changed.
- R6: `evt` is set on the clock edge where MDC falls at the end of slot 63. That edge comes 128 × speed clocks after the frame write.
- R7: `evt` is cleared by a flag write whose data bit is 1. A flag write with data 0 has no effect. If a clear and a completion fall in the same cycle, the flag stays set.
- R8: A frame write while a transaction is in progress is ignored. The frame word and the running transaction are not affected.
- R9: Writing a speed of 0 during a transaction freezes MDC and MDIO. Writing the earlier speed back resumes the transaction at the point where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_wr | input | 1 | Frame word write strobe; starts a transaction when idle |
| frame_wdata | input | 32 | Frame word write data |
| frame_q | output | 32 | Current frame word, holding read data after a read |
| spd_wr | input | 1 | Speed write strobe |
| spd_wdata | input | SPD_W | Speed value (MDC half period in clocks) |
| evt_wr | input | 1 | Completion flag write strobe |
| evt_wdata | input | 1 | Completion flag write data; 1 clears |
| evt | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO input value from the line |

## Verification
The completion event and a host clear can land on the same clock edge. A frame write can also arrive on the edge that ends a transaction, while the engine still counts as busy. The bench provokes the collision by counting exactly 128 × speed clocks after a frame write and holding the clear strobe across that edge. It then expects the flag still set, because the set has priority. A behavioural model counts clocks since the start of the transaction and predicts MDC, MDIO, the enable, the flag and the frame word; the bench compares the design against this model on every cycle, including during a speed-zero stall and a write that arrives while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS    = 32;
    localparam int PREAMBLE_BITS = 32;
    localparam int DATA_BITS     = 16;
    localparam int SLOT_COUNT    = PREAMBLE_BITS + FRAME_BITS;
    localparam int SLOT_W        = $clog2(SLOT_COUNT);

    // slot of the second turnaround bit, where a read releases the line
    localparam logic [SLOT_W-1:0] RELEASE_SLOT = SLOT_W'(SLOT_COUNT - DATA_BITS - 1);
    // first slot whose rising MDC edge captures read data
    localparam logic [SLOT_W-1:0] CAPTURE_SLOT = SLOT_W'(SLOT_COUNT - DATA_BITS);
    localparam logic [SLOT_W-1:0] LAST_SLOT    = SLOT_W'(SLOT_COUNT - 1);

    localparam logic [1:0] OPC_READ = 2'b10;

    typedef struct packed {
        logic [1:0]           start_code;
        logic [1:0]           opcode;
        logic [4:0]           phy_addr;
        logic [4:0]           reg_addr;
        logic [1:0]           turn;
        logic [DATA_BITS-1:0] data;
    } mgmt_frame_t;

    typedef enum logic {SEQ_IDLE, SEQ_SHIFT} seq_state_e;

    function automatic logic is_read(mgmt_frame_t f);
        return f.opcode == OPC_READ;
    endfunction

    // preamble and frame are both 2**(SLOT_W-1) long: the top slot bit
    // selects the half, the inverted low bits give the MSB-first index
    function automatic logic slot_bit(mgmt_frame_t f, logic [SLOT_W-1:0] s);
        logic [FRAME_BITS-1:0] v;
        logic [SLOT_W-2:0]     pos;
        v   = f;
        pos = s[SLOT_W-2:0];
        return s[SLOT_W-1] ? v[~pos] : 1'b1;
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SPD_W-1:0] spd,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [SPD_W-1:0] div_cnt;
    logic             active;
    logic             tick;

    always_comb begin
        active   = run && (spd != '0);
        tick     = active && (div_cnt >= spd - SPD_W'(1));
        rise_stb = tick && !mdc;
        fall_stb = tick && mdc;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else if (active) begin
            if (tick) begin
                div_cnt <= '0;
                mdc     <= ~mdc;
            end else begin
                div_cnt <= div_cnt + SPD_W'(1);
            end
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  mgmt_frame_t load_val,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output mgmt_frame_t frame,
    output logic        mdio_o,
    output logic        mdio_oe
);

    seq_state_e        state;
    logic [SLOT_W-1:0] slot;
    logic              rd;

    always_comb begin
        busy    = (state == SEQ_SHIFT);
        rd      = is_read(frame);
        done    = busy && fall_stb && (slot == LAST_SLOT);
        mdio_o  = slot_bit(frame, slot);
        mdio_oe = busy && !(rd && slot >= RELEASE_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            slot  <= '0;
            frame <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (load) begin
                        frame <= load_val;
                        slot  <= '0;
                        state <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (rise_stb && rd && slot >= CAPTURE_SLOT) begin
                        frame.data <= {frame.data[DATA_BITS-2:0], mdio_i};
                    end
                    if (fall_stb) begin
                        if (slot == LAST_SLOT) begin
                            slot  <= '0;
                            state <= SEQ_IDLE;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_pkg::*;
#(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_wr,
    input  logic [31:0]      frame_wdata,
    output logic [31:0]      frame_q,
    input  logic             spd_wr,
    input  logic [SPD_W-1:0] spd_wdata,
    input  logic             evt_wr,
    input  logic             evt_wdata,
    output logic             evt,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic [SPD_W-1:0] spd_q;
    logic             busy;
    logic             done;
    logic             rise_stb;
    logic             fall_stb;
    mgmt_frame_t      frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            spd_q <= '0;
            evt   <= 1'b0;
        end else begin
            if (spd_wr) spd_q <= spd_wdata;
            // completion outranks a clear in the same cycle
            if (done)                      evt <= 1'b1;
            else if (evt_wr && evt_wdata)  evt <= 1'b0;
        end
    end

    mdc_divider #(.SPD_W(SPD_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .spd      (spd_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_wr),
        .load_val (mgmt_frame_t'(frame_wdata)),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .frame    (frame),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    assign frame_q = frame;

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
    parameter int SPD_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             evt,
    input logic             evt_wr,
    input logic             evt_wdata,
    input logic             frame_wr,
    input logic [31:0]      frame_q,
    input logic [SPD_W-1:0] spd_q
);

    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R9
    mdc_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (spd_q == '0) |=> $stable(mdc));

    // R3
    mdio_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

    // R6
    evt_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(evt) |-> $fell(mdc));

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !(evt_wr && evt_wdata)) |=> evt);

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && frame_wr) |=> $stable(frame_q[31:16]));

    // R5
    upper_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mdio_oe) |=> $stable(frame_q[31:16]));

endmodule

bind mdio_mgmt_engine mdio_mgmt_chk #(.SPD_W(SPD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .evt       (evt),
    .evt_wr    (evt_wr),
    .evt_wdata (evt_wdata),
    .frame_wr  (frame_wr),
    .frame_q   (frame_q),
    .spd_q     (spd_q)
);

// File: tb/mdio_mgmt_engine_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_engine_tb;

    localparam int SPD_W = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_wr;
    logic [31:0]      frame_wdata;
    logic [31:0]      frame_q;
    logic             spd_wr;
    logic [SPD_W-1:0] spd_wdata;
    logic             evt_wr;
    logic             evt_wdata;
    logic             evt;
    logic             mdc;
    logic             mdio_o;
    logic             mdio_oe;
    logic             mdio_i;

    always #2.5 clk = ~clk;

    mdio_mgmt_engine #(.SPD_W(SPD_W)) u_dut (
        .clk (clk), .rst (rst),
        .frame_wr (frame_wr), .frame_wdata (frame_wdata), .frame_q (frame_q),
        .spd_wr (spd_wr), .spd_wdata (spd_wdata),
        .evt_wr (evt_wr), .evt_wdata (evt_wdata), .evt (evt),
        .mdc (mdc), .mdio_o (mdio_o), .mdio_oe (mdio_oe), .mdio_i (mdio_i)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference: clocks elapsed since the transaction began
    bit          m_busy;
    bit          m_evt;
    bit          m_done;
    bit          m_was_busy;
    int          m_t;
    int          m_s;
    int          m_spd;
    int          m_b;
    logic [31:0] m_frame;
    logic [15:0] resp;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_evt = 0; m_t = 0; m_s = 1; m_spd = 0; m_frame = '0;
        end else begin
            m_was_busy = m_busy;
            m_done     = 0;
            if (m_busy && m_spd != 0) begin
                m_b = m_t / (2 * m_s);
                m_t++;
                if ((m_t % m_s) == 0 && ((m_t / m_s) % 2) == 1 &&
                    m_frame[29:28] == 2'b10 && m_b >= 48)
                    m_frame[15:0] = {m_frame[14:0], mdio_i};
                if (m_t == 128 * m_s) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end
            if (m_done) m_evt = 1;
            else if (evt_wr && evt_wdata) m_evt = 0;
            if (frame_wr && !m_was_busy) begin
                m_frame = frame_wdata; m_busy = 1; m_t = 0; m_s = m_spd;
            end
            if (spd_wr) m_spd = int'(spd_wdata);
        end
    end

    // PHY responder and per-cycle comparison, both away from the active edge
    always @(negedge clk) begin
        int  b;
        bit  rd;
        bit  e_mdc;
        bit  e_oe;
        bit  e_o;
        b     = m_busy ? m_t / (2 * m_s) : 0;
        rd    = (m_frame[29:28] == 2'b10);
        e_mdc = m_busy && (((m_t / m_s) % 2) == 1);
        e_oe  = m_busy && !(rd && b >= 47);
        e_o   = (!m_busy || b < 32) ? 1'b1 : m_frame[63 - b];
        if (m_busy && b >= 48) mdio_i <= resp[63 - b];
        else                   mdio_i <= 1'b0;
        if (!rst) begin
            chk("R2 mdc", 32'(mdc), 32'(e_mdc));
            chk("R5 mdio_oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe) chk("R3 mdio_o", 32'(mdio_o), 32'(e_o));
            chk("R6 evt", 32'(evt), 32'(m_evt));
            chk("R8 frame_q", frame_q, m_frame);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 100000);
            finish_up();
        end
    end

    task automatic wr_spd(int v);
        @(negedge clk); spd_wr = 1; spd_wdata = SPD_W'(v);
        @(negedge clk); spd_wr = 0;
    endtask

    task automatic start_frame(logic [31:0] f);
        @(negedge clk); frame_wr = 1; frame_wdata = f;
        @(negedge clk); frame_wr = 0;
    endtask

    task automatic flag_write(logic d);
        @(negedge clk); evt_wr = 1; evt_wdata = d;
        @(negedge clk); evt_wr = 0;
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    logic [31:0] fw;
    logic        held_mdc;

    initial begin
        rst = 1; frame_wr = 0; frame_wdata = '0; spd_wr = 0; spd_wdata = '0;
        evt_wr = 0; evt_wdata = 0; mdio_i = 0; resp = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 mdc", 32'(mdc), 0);
        chk("R1 mdio_oe", 32'(mdio_oe), 0);
        chk("R1 evt", 32'(evt), 0);
        chk("R1 frame_q", frame_q, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk("R2 idle mdc low", 32'(mdc), 0);

        // R4 write transaction at speed 2
        wr_spd(2);
        fw = {2'b01, 2'b01, 5'h03, 5'h11, 2'b10, 16'hBEEF};
        start_frame(fw);
        wait_idle();
        chk("R6 evt after write", 32'(evt), 1);
        chk("R4 frame kept", frame_q, fw);

        // R7 write of 0 leaves flag, write of 1 clears it
        flag_write(1'b0);
        chk("R7 zero write no effect", 32'(evt), 1);
        flag_write(1'b1);
        chk("R7 clear", 32'(evt), 0);

        // R5 read at speed 3
        wr_spd(3);
        resp = 16'hA5C3;
        fw = {2'b01, 2'b10, 5'h1F, 5'h02, 2'b10, 16'h1234};
        start_frame(fw);
        wait_idle();
        chk("R5 read data", frame_q, {fw[31:16], 16'hA5C3});
        flag_write(1'b1);

        // R8 read at speed 1 with a second write while busy
        wr_spd(1);
        resp = 16'h8001;
        fw = {2'b01, 2'b10, 5'h05, 5'h1A, 2'b10, 16'h0000};
        start_frame(fw);
        repeat (20) @(negedge clk);
        start_frame(32'h5FFF_FFFF);
        chk("R8 busy write ignored", frame_q[31:16], 32'(fw[31:16]));
        wait_idle();
        chk("R8 result intact", frame_q, {fw[31:16], 16'h8001});
        flag_write(1'b1);

        // R7 clear on the completion edge: set wins
        wr_spd(2);
        fw = {2'b01, 2'b01, 5'h00, 5'h00, 2'b10, 16'h0F0F};
        start_frame(fw);
        repeat (128 * 2 - 1) @(negedge clk);
        evt_wr = 1; evt_wdata = 1;
        @(negedge clk); evt_wr = 0;
        chk("R7 completion beats clear", 32'(evt), 1);
        flag_write(1'b1);

        // R9 speed 0 stall mid-transaction
        wr_spd(4);
        resp = 16'h3C96;
        fw = {2'b01, 2'b10, 5'h0A, 5'h0B, 2'b10, 16'hFFFF};
        start_frame(fw);
        repeat (150) @(negedge clk);
        wr_spd(0);
        held_mdc = mdc;
        repeat (25) @(negedge clk);
        chk("R9 mdc frozen", 32'(mdc), 32'(held_mdc));
        chk("R9 no completion during stall", 32'(evt), 0);
        wr_spd(4);
        wait_idle();
        chk("R9 resumed read", frame_q, {fw[31:16], 16'h3C96});
        chk("R6 evt after stall", 32'(evt), 1);

        finish_up();
    end

endmodule